// File: doc/BRIEF.md
# Tuning-Word Update Sequencer

This block closes a frequency-tracking loop entirely in logic. On every pass it reads one signed sample of a frequency-error voltage from a serial converter and scales that sample by a programmable gain, in millihertz per volt, into a frequency offset. It adds the offset to a programmable center frequency, given in millihertz. It then turns the sum into a 32-bit phase increment for a synthesizer clocked at 1 MHz and writes that increment to the synthesizer as two 16-bit serial frames. After the write it pulses a strobe for a display, and it starts the next pass if the loop is still enabled.

Both serial links are masters with an idle-low clock. Each data bit is presented for a programmable number of system clocks before the rising edge and sampled on that edge. The converter link only receives and the synthesizer link only transmits. The synthesizer chip select stays low across both halves of a word, so the synthesizer never holds a half-updated frequency. Results below zero or above half the synthesizer clock are clipped.

Top module: `fdq_seq_top`

## Requirements
- R1: While and directly after reset, `busy` is 0, both chip selects are 1, both serial clocks are 0, `disp_stb` is 0 and `cur_word` is 0.
- R2: While `loop_en` is 0 and no pass is running, neither chip select goes low and `busy` stays 0.
- R3: A converter read is one frame of exactly 14 rising clock edges with `adc_cs_n` low. The bits are taken most significant first on each rising edge and form a two's complement code, so one code step is 20/16384 V.
- R4: The word written is round-half-up of (center·4096 + code·gain·5)·72057594 / 2^36. Here center is `center_mhz` in mHz, gain is `gain_mhz_v` in mHz/V and code is the signed converter code. This equals the output frequency times 2^32 divided by 1 MHz.
- R5: A word that would be negative is written as 0.
- R6: A word above 0x8000_0000 (half the synthesizer clock) is written as 0x8000_0000.
- R7: The synthesizer write has exactly 32 rising clock edges inside a single low period of `syn_cs_n`. Bits 31..16 go first, then bits 15..0, each half most significant bit first, and data is stable at each rising edge.
- R8: Each pass runs in a fixed order: converter read, compute, synthesizer write, then a one-clock `disp_stb` pulse in the cycle in which `syn_cs_n` returns high. The two chip selects are never low together, and a new pass follows at once while `loop_en` stays 1.
- R9: If `loop_en` is cleared before a converter frame ends, that frame still completes, no synthesizer write follows and the block returns to idle.
- R10: If `loop_en` is cleared during a synthesizer write, both halves are still sent and the strobe is still given before the block goes idle.
- R11: `busy` is 1 from the first cycle of a pass until the block is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| loop_en | input | 1 | Runs passes while high |
| center_mhz | input | 32 | Center frequency in mHz |
| gain_mhz_v | input | 16 | Conversion factor in mHz per volt |
| busy | output | 1 | A pass is in progress |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_miso | input | 1 | Converter serial data |
| syn_cs_n | output | 1 | Synthesizer chip select, active low |
| syn_sclk | output | 1 | Synthesizer serial clock |
| syn_mosi | output | 1 | Synthesizer serial data |
| disp_stb | output | 1 | One-cycle display update pulse |
| cur_word | output | 32 | Most recently computed phase increment |

## Verification
A zero code isolates the center-frequency conversion and its rounding. Small positive and negative codes with a moderate gain show that the deviation has the right sign and that the product is aligned correctly. The two extreme codes with the largest gain check the sign extension of the 14-bit sample and the width of the product. A near-zero center with a large negative deviation, and a center above the Nyquist point, select the two clip paths. Clearing the enable during the converter frame and again during the synthesizer frame shows which transfers finish and whether a write or strobe follows.

// File: rtl/fdq_pkg.sv
package fdq_pkg;

    localparam int ADC_W   = 14;              // converter sample width
    localparam int HALF_W  = 16;              // synthesizer frame width
    localparam int WORD_W  = 2 * HALF_W;      // phase increment width
    localparam int CEN_W   = 32;              // center frequency, mHz
    localparam int GAIN_W  = 16;              // gain, mHz per volt

    // one code step = 20 V / 2^14 = LSB_NUM / 2^LSB_SH volt
    localparam int LSB_SH  = 12;
    localparam int LSB_NUM = 5;

    // 2^32 / 1e9 (mHz at a 1 MHz clock) in fixed point with K_FRAC bits
    localparam int     K_FRAC  = 24;
    localparam longint K_SCALE = 72057594;
    localparam int     K_W     = $clog2(K_SCALE + 1);

    localparam int SHIFT  = K_FRAC + LSB_SH;
    localparam int MUL_W  = ADC_W + GAIN_W + 1;
    localparam int SUM_W  = CEN_W + LSB_SH + 2;
    localparam int PROD_W = SUM_W + K_W + 1;

    localparam logic [WORD_W-1:0] NYQ_WORD = WORD_W'(1) << (WORD_W - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADC,
        S_CALC,
        S_HI,
        S_LO,
        S_SHOW
    } seq_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tword_t;

    function automatic logic [WORD_W-1:0] clamp_word(input logic signed [PROD_W-1:0] v);
        logic signed [PROD_W-1:0] lim;
        lim = $signed(PROD_W'(1) << (WORD_W - 1));
        if (v[PROD_W-1]) return '0;
        if (v > lim) return NYQ_WORD;
        return v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/fdq_sclk_gen.sv
module fdq_sclk_gen #(
    parameter int BITS = 16,
    parameter int DIV  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic sclk,
    output logic rise_now,
    output logic fall_now,
    output logic done
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW = $clog2(BITS + 1);

    logic          run_q;
    logic [DW-1:0] div_q;
    logic [BW-1:0] left_q;
    logic          tick;

    assign tick     = run_q && (div_q == DW'(DIV - 1));
    assign rise_now = tick && !sclk;
    assign fall_now = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            div_q  <= '0;
            left_q <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run_q) begin
                run_q  <= 1'b1;
                div_q  <= '0;
                left_q <= BW'(BITS);
                sclk   <= 1'b0;
            end else if (run_q) begin
                div_q <= tick ? '0 : div_q + 1'b1;
                if (rise_now) sclk <= 1'b1;
                if (fall_now) begin
                    sclk   <= 1'b0;
                    left_q <= left_q - 1'b1;
                    if (left_q == BW'(1)) begin
                        run_q <= 1'b0;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end

    // R7: the serial clock only toggles inside a running frame
    a_r7_sclk_parked: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !sclk);

    // R8: the end-of-frame marker lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: a frame ends only after its final bit
    a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> !run_q && (left_q == '0));

endmodule

// File: rtl/fdq_adc_rd.sv
module fdq_adc_rd #(
    parameter int W   = 14,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         miso,
    output logic         sclk,
    output logic         done,
    output logic [W-1:0] data
);
    logic rise_now;
    logic fall_now;
    logic [W-1:0] rx_q;

    fdq_sclk_gen #(.BITS(W), .DIV(DIV)) gen_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sclk    (sclk),
        .rise_now(rise_now),
        .fall_now(fall_now),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (rise_now) begin
            rx_q <= {rx_q[W-2:0], miso};
        end
    end

    assign data = rx_q;

    // R3: received bits change only at a sampling edge
    a_r3_rx_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$past(rise_now) |-> $stable(rx_q));

endmodule

// File: rtl/fdq_syn_wr.sv
module fdq_syn_wr #(
    parameter int W   = 16,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] word,
    output logic         sclk,
    output logic         mosi,
    output logic         done
);
    logic rise_now;
    logic fall_now;
    logic [W-1:0] tx_q;

    fdq_sclk_gen #(.BITS(W), .DIV(DIV)) gen_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sclk    (sclk),
        .rise_now(rise_now),
        .fall_now(fall_now),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (start) begin
            tx_q <= word;
        end else if (fall_now) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    assign mosi = tx_q[W-1];

    // R7: data seen by the synthesizer is steady across a rising edge
    a_r7_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

endmodule

// File: rtl/fdq_word_calc.sv
module fdq_word_calc
    import fdq_pkg::*;
(
    input  logic [CEN_W-1:0]  center,
    input  logic [GAIN_W-1:0] gain,
    input  logic [ADC_W-1:0]  code,
    output tword_t            word
);
    logic signed [MUL_W-1:0]  code_x;
    logic signed [MUL_W-1:0]  gain_x;
    logic signed [MUL_W-1:0]  mul;
    logic signed [SUM_W-1:0]  cen_x;
    logic signed [SUM_W-1:0]  dev_x;
    logic signed [SUM_W-1:0]  sum;
    logic signed [PROD_W-1:0] sum_w;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    logic signed [PROD_W-1:0] res;

    always_comb begin
        code_x = {{(MUL_W - ADC_W){code[ADC_W-1]}}, code};
        gain_x = {{(MUL_W - GAIN_W){1'b0}}, gain};
        mul    = code_x * gain_x;
        dev_x  = {{(SUM_W - MUL_W){mul[MUL_W-1]}}, mul} * SUM_W'(LSB_NUM);
        cen_x  = {{(SUM_W - CEN_W - LSB_SH){1'b0}}, center, {LSB_SH{1'b0}}};
        sum    = cen_x + dev_x;
        sum_w  = {{(PROD_W - SUM_W){sum[SUM_W-1]}}, sum};
        prod   = sum_w * PROD_W'(K_SCALE);
        rnd    = prod + $signed(PROD_W'(1) << (SHIFT - 1));
        res    = rnd >>> SHIFT;
        word   = clamp_word(res);
    end

endmodule

// File: rtl/fdq_seq_top.sv
module fdq_seq_top
    import fdq_pkg::*;
#(
    parameter int SCLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic [CEN_W-1:0]  center_mhz,
    input  logic [GAIN_W-1:0] gain_mhz_v,
    output logic              busy,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_miso,
    output logic              syn_cs_n,
    output logic              syn_sclk,
    output logic              syn_mosi,
    output logic              disp_stb,
    output logic [WORD_W-1:0] cur_word
);
    seq_e              st_q;
    logic              adc_go_q;
    logic              syn_go_q;
    logic              adc_done;
    logic              syn_done;
    logic [ADC_W-1:0]  adc_data;
    logic [ADC_W-1:0]  code_q;
    logic [HALF_W-1:0] syn_tx_q;
    tword_t            calc_w;
    tword_t            word_q;

    fdq_adc_rd #(.W(ADC_W), .DIV(SCLK_DIV)) adc_i (
        .clk  (clk),
        .rst  (rst),
        .start(adc_go_q),
        .miso (adc_miso),
        .sclk (adc_sclk),
        .done (adc_done),
        .data (adc_data)
    );

    fdq_word_calc calc_i (
        .center(center_mhz),
        .gain  (gain_mhz_v),
        .code  (code_q),
        .word  (calc_w)
    );

    fdq_syn_wr #(.W(HALF_W), .DIV(SCLK_DIV)) syn_i (
        .clk  (clk),
        .rst  (rst),
        .start(syn_go_q),
        .word (syn_tx_q),
        .sclk (syn_sclk),
        .mosi (syn_mosi),
        .done (syn_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            adc_cs_n <= 1'b1;
            syn_cs_n <= 1'b1;
            adc_go_q <= 1'b0;
            syn_go_q <= 1'b0;
            code_q   <= '0;
            word_q   <= '0;
            syn_tx_q <= '0;
            disp_stb <= 1'b0;
        end else begin
            adc_go_q <= 1'b0;
            syn_go_q <= 1'b0;
            disp_stb <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (loop_en) begin
                        adc_cs_n <= 1'b0;
                        adc_go_q <= 1'b1;
                        st_q     <= S_ADC;
                    end
                end
                S_ADC: begin
                    if (adc_done) begin
                        adc_cs_n <= 1'b1;
                        code_q   <= adc_data;
                        st_q     <= loop_en ? S_CALC : S_IDLE;
                    end
                end
                S_CALC: begin
                    word_q   <= calc_w;
                    syn_tx_q <= calc_w.hi;
                    syn_cs_n <= 1'b0;
                    syn_go_q <= 1'b1;
                    st_q     <= S_HI;
                end
                S_HI: begin
                    if (syn_done) begin
                        syn_tx_q <= word_q.lo;
                        syn_go_q <= 1'b1;
                        st_q     <= S_LO;
                    end
                end
                S_LO: begin
                    if (syn_done) begin
                        syn_cs_n <= 1'b1;
                        disp_stb <= 1'b1;
                        st_q     <= S_SHOW;
                    end
                end
                S_SHOW: begin
                    if (loop_en) begin
                        adc_cs_n <= 1'b0;
                        adc_go_q <= 1'b1;
                        st_q     <= S_ADC;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != S_IDLE);
    assign cur_word = word_q;

    // R8: the two devices are never selected together
    a_r8_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!adc_cs_n && !syn_cs_n));

    // R8: releasing the synthesizer coincides with the display strobe
    a_r8_stb_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(syn_cs_n) |-> disp_stb);

    // R7: the synthesizer clock runs only while it is selected
    a_r7_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        syn_sclk |-> !syn_cs_n);

    // R3: the converter clock runs only while it is selected
    a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_cs_n);

    // R6: no word above half the synthesizer clock ever leaves the block
    a_r6_word_ceiling: assert property (@(posedge clk) disable iff (rst)
        cur_word <= NYQ_WORD);

    // R11: idle means both devices deselected
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> adc_cs_n && syn_cs_n);

    // R9: a converter frame ending with the loop disabled returns to idle
    a_r9_stop_after_read: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_ADC && adc_done && !loop_en) |=> !busy && syn_cs_n);

endmodule

// File: tb/fdq_seq_top_tb_top.sv
module fdq_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loop_en = 1'b0;
    logic [31:0] center = '0;
    logic [15:0] gain = '0;
    logic        busy, adc_cs_n, adc_sclk, adc_miso;
    logic        syn_cs_n, syn_sclk, syn_mosi, disp_stb;
    logic [31:0] cur_word;

    always #5 clk = ~clk;

    fdq_seq_top #(.SCLK_DIV(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .loop_en   (loop_en),
        .center_mhz(center),
        .gain_mhz_v(gain),
        .busy      (busy),
        .adc_cs_n  (adc_cs_n),
        .adc_sclk  (adc_sclk),
        .adc_miso  (adc_miso),
        .syn_cs_n  (syn_cs_n),
        .syn_sclk  (syn_sclk),
        .syn_mosi  (syn_mosi),
        .disp_stb  (disp_stb),
        .cur_word  (cur_word)
    );

    int n_chk = 0;
    int n_bad = 0;
    string cur_tag = "R4";

    logic [13:0] code_q[$];
    logic [31:0] exp_q[$];

    int adc_frames = 0, adc_rise = 0, adc_last_bits = 0;
    int syn_frames = 0, syn_bits = 0;
    int stb_cnt = 0;
    bit adc_on = 0, syn_on = 0;
    logic [13:0] adc_sh = '0;
    logic [31:0] syn_sh = '0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic [31:0] cen, logic signed [13:0] code, logic [15:0] g);
        logic signed [127:0] c, s, p;
        c = code;
        s = $signed({96'd0, cen}) * 4096 + c * $signed({112'd0, g}) * 5;
        p = s * 72057594 + (128'sd1 <<< 35);
        p = p >>> 36;
        if (p < 0) return 32'h0;
        if (p > 128'sd2147483648) return 32'h8000_0000;
        return p[31:0];
    endfunction

    // converter model: shifts out the next queued code, MSB first
    always @(negedge adc_cs_n or posedge adc_cs_n or posedge adc_sclk or negedge adc_sclk) begin
        if (rst) begin
            adc_on = 0;
        end else if (adc_cs_n) begin
            if (adc_on) begin
                adc_frames++;
                adc_last_bits = adc_rise;
                check(adc_rise == 14, "R3", "converter frame edges", adc_rise, 14);
            end
            adc_on = 0;
        end else if (!adc_on) begin
            adc_on = 1;
            adc_rise = 0;
            adc_sh = (code_q.size() > 0) ? code_q.pop_front() : 14'h0;
        end else if (adc_sclk) begin
            adc_rise++;
        end else begin
            adc_sh = {adc_sh[12:0], 1'b0};
        end
    end
    assign adc_miso = adc_sh[13];

    // scoreboard monitor for synthesizer writes
    always @(negedge syn_cs_n or posedge syn_cs_n or posedge syn_sclk) begin
        if (rst) begin
            syn_on = 0;
        end else if (syn_cs_n) begin
            if (syn_on) begin
                syn_frames++;
                check(syn_bits == 32, "R7", "edges in one select window", syn_bits, 32);
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "write with nothing expected", syn_sh, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(syn_sh == e, cur_tag, "tuning word", syn_sh, e);
                end
            end
            syn_on = 0;
        end else if (!syn_on) begin
            syn_on = 1;
            syn_bits = 0;
            syn_sh = '0;
        end else if (syn_sclk) begin
            syn_sh = {syn_sh[30:0], syn_mosi};
            syn_bits++;
        end
    end

    // strobe monitor, sampled between edges
    always @(negedge clk) begin
        if (!rst && disp_stb) begin
            stb_cnt++;
            check(syn_cs_n && (syn_frames == stb_cnt), "R8",
                  "strobe after released write", syn_frames, stb_cnt);
        end
    end

    task automatic queue_pass(logic [31:0] cen, logic signed [13:0] code, logic [15:0] g);
        code_q.push_back(code);
        exp_q.push_back(model(cen, code, g));
    endtask

    task automatic run_passes(int n, string tag);
        int s0;
        s0 = stb_cnt;
        cur_tag = tag;
        @(negedge clk);
        loop_en = 1'b1;
        while (stb_cnt < s0 + n) @(negedge clk);
        loop_en = 1'b0;
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R8", "all passes written in order", exp_q.size(), 0);
        check(busy == 1'b0, "R11", "busy low once idle", busy, 0);
        code_q.delete();
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(adc_cs_n == 1 && syn_cs_n == 1, "R1", "selects in reset", {adc_cs_n, syn_cs_n}, 3);
        check(adc_sclk == 0 && syn_sclk == 0, "R1", "clocks in reset", {adc_sclk, syn_sclk}, 0);
        check(disp_stb == 0, "R1", "strobe in reset", disp_stb, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cur_word == 0 && busy == 0, "R1", "state after reset", cur_word, 0);

        // R2: disabled loop stays quiet
        begin
            int hits;
            hits = 0;
            center = 32'd32768000;
            gain = 16'd2000;
            repeat (300) begin
                @(negedge clk);
                if (busy || !adc_cs_n || !syn_cs_n) hits++;
            end
            check(hits == 0, "R2", "activity while disabled", hits, 0);
            check(adc_frames == 0 && syn_frames == 0, "R2", "frames while disabled", adc_frames + syn_frames, 0);
        end

        // R4: center only, small deviations of both signs, back to back passes (R8)
        queue_pass(32'd32768000, 14'sd0, 16'd2000);
        queue_pass(32'd32768000, 14'sd1000, 16'd2000);
        queue_pass(32'd32768000, -14'sd1000, 16'd2000);
        run_passes(3, "R4");
        check(cur_word == model(32'd32768000, -14'sd1000, 16'd2000), "R4", "display word", cur_word,
              model(32'd32768000, -14'sd1000, 16'd2000));

        // R3/R4: extreme codes with the largest gain
        center = 32'd32768000;
        gain = 16'hFFFF;
        queue_pass(32'd32768000, 14'sd8191, 16'hFFFF);
        queue_pass(32'd32768000, -14'sd8192, 16'hFFFF);
        run_passes(2, "R3");

        // R5: clip below zero
        center = 32'd1000;
        queue_pass(32'd1000, -14'sd8192, 16'hFFFF);
        run_passes(1, "R5");
        check(cur_word == 32'h0, "R5", "low clip word", cur_word, 0);

        // R6: clip above half the clock, and a value just below it
        center = 32'd600000000;
        gain = 16'd0;
        queue_pass(32'd600000000, 14'sd0, 16'd0);
        run_passes(1, "R6");
        check(cur_word == 32'h8000_0000, "R6", "high clip word", cur_word, 32'h8000_0000);
        center = 32'd499000000;
        queue_pass(32'd499000000, 14'sd0, 16'd0);
        run_passes(1, "R6");

        // R9: disable during the converter frame
        begin
            int a0, s0, b0;
            a0 = adc_frames;
            s0 = syn_frames;
            b0 = stb_cnt;
            cur_tag = "R9";
            code_q.push_back(14'sd77);
            @(negedge clk);
            loop_en = 1'b1;
            while (adc_cs_n) @(negedge clk);
            loop_en = 1'b0;
            while (busy) @(negedge clk);
            repeat (20) @(negedge clk);
            check(adc_frames == a0 + 1, "R9", "converter frame completed", adc_frames, a0 + 1);
            check(adc_last_bits == 14, "R9", "converter frame length", adc_last_bits, 14);
            check(syn_frames == s0, "R9", "no synthesizer write", syn_frames, s0);
            check(stb_cnt == b0, "R9", "no strobe", stb_cnt, b0);
        end

        // R10: disable during the synthesizer write
        begin
            int s0, b0;
            s0 = syn_frames;
            b0 = stb_cnt;
            center = 32'd40000000;
            gain = 16'd5000;
            queue_pass(32'd40000000, -14'sd321, 16'd5000);
            cur_tag = "R10";
            @(negedge clk);
            loop_en = 1'b1;
            while (syn_cs_n) @(negedge clk);
            check(busy == 1'b1, "R11", "busy during write", busy, 1);
            loop_en = 1'b0;
            while (busy) @(negedge clk);
            check(syn_frames == s0 + 1, "R10", "write completed", syn_frames, s0 + 1);
            check(stb_cnt == b0 + 1, "R10", "strobe given", stb_cnt, b0 + 1);
            check(exp_q.size() == 0, "R10", "word delivered", exp_q.size(), 0);
            repeat (20) @(negedge clk);
            check(busy == 0 && adc_cs_n == 1, "R10", "idle afterwards", busy, 0);
        end

        report();
        $finish;
    end

endmodule